// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives characters on a single asynchronous serial line. A fixed clock divider produces sixteen sample ticks per bit period. The receiver checks each start bit and then takes every later bit at the middle of its period. A character has 7 or 8 data bits, sent least significant bit first. An optional even or odd parity bit follows the data, then one or two stop bits. The finished character is placed in a receive data register.

Software reaches three byte registers through a small bus with address, read strobe, write strobe and write data. Read data is combinational and follows the address.

The status register holds three flags: receive-full, framing error and parity error. Each flag clears in two steps:
- Software reads the flag while it is 1, which arms it.
- Software then writes 0 to it.

While an error flag is set, the receiver ignores the line. An erroneous character is still stored in the data register, but it does not raise the receive-full flag. Two interrupt outputs combine the flags with their enable bits.

Top module: `async_rx_flags`

## Requirements
- R1: A falling edge on the line starts a character only if the line is still low eight sample ticks later. A shorter low pulse is dropped, and neither the data register nor the status register changes.
- R2: Data bits arrive least significant bit first. Control bit 3 selects 7 data bits instead of 8. In 7-bit mode, bit 7 of the data register (address 2) reads as 0.
- R3: A character with no error is written to the data register and sets the receive-full flag (status bit 0, address 1).
- R4: Control bit 1 enables a parity bit after the data. Control bit 2 selects odd parity instead of even. A parity bit that does not give the selected parity over the data bits sets the parity-error flag (status bit 2).
- R5: A first stop bit sampled as 0 sets the framing-error flag (status bit 1). Control bit 4 selects two stop bits. In that mode the second stop bit is never checked and cannot cause a framing error.
- R6: A character with a parity or framing error is still written to the data register, but the receive-full flag is left unchanged.
- R7: While either error flag is 1, incoming characters are ignored and the data register keeps its value.
- R8: Each status flag is cleared only by a write of 0 to its bit that follows a status read in which that flag was 1. The first write to the status register after a read consumes that read. A write of 0 without an armed read, or a write of 1, leaves the flag as it was.
- R9: Reading the data register does not clear the receive-full flag.
- R10: While control bit 0 (receive enable) is 0, no character is received. Clearing receive enable leaves both error flags unchanged.
- R11: `irq_full` is high when the receive-full flag and control bit 5 are both 1. `irq_err` is high when either error flag is 1 and control bit 6 is 1.
- R12: After reset, the control register, the status register and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| rd | input | 1 | Read strobe; arms the status flags |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq_full | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The hardest states to reach are these:
- the frozen receiver, where a well-formed character arrives while an error flag is set;
- the unarmed clear, where a write of 0 comes without a qualifying read.

The stimulus reaches the frozen state by first sending a character with a wrong parity bit. It then sends a clean character, and the data register must still hold the bad character.

For the clear protocol, the armed read is used up by a write of 1. A following write of 0 must then leave the flag set. Only a fresh read followed by a write of 0 may clear it.

For the second stop bit, the bench sends characters that break only that bit.

// File: rtl/async_rx_flags.sv
module async_rx_flags #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic [1:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_full,
  output logic       irq_err
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_START = 2'd1, ST_BITS = 2'd2, ST_TAIL = 2'd3;

  logic [2:0]    sync;
  logic [7:0]    ctrl;
  logic          full, ferr, perr;
  logic [2:0]    arm;
  logic [7:0]    rbuf;
  logic [1:0]    st;
  logic [DW-1:0] dcnt;
  logic [3:0]    tcnt, bidx;
  logic [8:0]    sh;

  wire line  = sync[1];
  wire fall  = sync[2] & ~sync[1];
  wire en    = ctrl[0];
  wire pe    = ctrl[1];
  wire podd  = ctrl[2];
  wire seven = ctrl[3];
  wire two   = ctrl[4];

  wire       tick    = (dcnt == DW'(DIV - 1));
  wire [3:0] last    = (seven ? 4'd7 : 4'd8) + {3'b000, pe};
  wire [7:0] dword   = seven ? {1'b0, sh[6:0]} : sh[7:0];
  wire       pbit    = seven ? sh[7] : sh[8];
  wire       pbad    = pe & (pbit != (^dword ^ podd));
  wire       stat_wr = wr & (addr == 2'd1);
  wire [2:0] clr     = arm & {perr, ferr, full} & ~wdata[2:0] & {3{stat_wr}};

  assign irq_full = full & ctrl[5];
  assign irq_err  = (ferr | perr) & ctrl[6];

  always_comb begin
    case (addr)
      2'd0:    rdata = ctrl;
      2'd1:    rdata = {5'b00000, perr, ferr, full};
      2'd2:    rdata = rbuf;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 3'b111;
      ctrl <= '0;
      full <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
      arm  <= '0;
      rbuf <= '0;
      st   <= ST_IDLE;
      dcnt <= '0;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
    end else begin
      sync <= {sync[1:0], rxd};
      if (wr && addr == 2'd0) ctrl <= wdata;
      if (rd && addr == 2'd1) arm <= {perr, ferr, full};
      else if (stat_wr)       arm <= '0;
      full <= full & ~clr[0];
      ferr <= ferr & ~clr[1];
      perr <= perr & ~clr[2];
      dcnt <= (st == ST_IDLE || tick) ? '0 : DW'(dcnt + 1'b1);

      case (st)
        ST_IDLE:
          if (en && !ferr && !perr && fall) begin
            st   <= ST_START;
            tcnt <= '0;
          end
        ST_START:
          if (tick) begin
            if (tcnt == 4'd7) begin
              if (line) st <= ST_IDLE;
              else begin
                st   <= ST_BITS;
                tcnt <= '0;
                bidx <= '0;
              end
            end else tcnt <= tcnt + 4'd1;
          end
        ST_BITS:
          if (tick) begin
            if (tcnt == 4'd15) begin
              tcnt <= '0;
              bidx <= bidx + 4'd1;
              for (int i = 0; i < 9; i++)
                if (bidx == 4'(i)) sh[i] <= line;
              if (bidx == last) begin
                rbuf <= dword;
                if (!line)         ferr <= 1'b1;
                if (pbad)          perr <= 1'b1;
                if (line && !pbad) full <= 1'b1;
                st <= two ? ST_TAIL : ST_IDLE;
              end
            end else tcnt <= tcnt + 4'd1;
          end
        default:
          if (tick) begin
            if (tcnt == 4'd15) st <= ST_IDLE;
            else tcnt <= tcnt + 4'd1;
          end
      endcase

      if (!en) st <= ST_IDLE;
    end
  end
endmodule

// File: rtl/async_rx_flags_chk.sv
module async_rx_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       full,
  input logic       ferr,
  input logic       perr,
  input logic       en,
  input logic       err_ie,
  input logic       irq_full,
  input logic       irq_err,
  input logic       busy
);
  p_err_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (err_ie && (ferr || perr)));

  p_full_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> full);

  p_ferr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr && !(wr && addr == 2'd1)) |=> ferr);

  p_perr_clear_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr) |-> $past(wr && addr == 2'd1 && !wdata[2]));

  p_err_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ferr || perr) && !busy) |=> !busy);

  p_no_full_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(perr) || $rose(ferr)) |-> !$rose(full));

  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

bind async_rx_flags async_rx_flags_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
  .full(full), .ferr(ferr), .perr(perr), .en(ctrl[0]), .err_ie(ctrl[6]),
  .irq_full(irq_full), .irq_err(irq_err), .busy(st != 2'd0)
);

// File: tb/async_rx_flags_tb_top.sv
module async_rx_flags_tb_top;
  localparam int DIV = 4;
  localparam int BITCLK = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic irq_full, irq_err;
  int total = 0, bad = 0;

  typedef struct { logic [7:0] data; logic [2:0] stat; string req; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  async_rx_flags #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .irq_full(irq_full), .irq_err(irq_err));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rxd = b;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit sev, input bit pe, input bit odd,
                            input bit two, input bit flip_par, input bit bad1, input bit bad2);
    int n = sev ? 7 : 8;
    logic par = ^(sev ? {1'b0, d[6:0]} : d) ^ odd ^ flip_par;
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i]);
    if (pe) send_bit(par);
    send_bit(!bad1);
    if (two) send_bit(!bad2);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic expect_item(input logic [7:0] d, input logic [2:0] s, input string req);
    exp_t e;
    e.data = d; e.stat = s; e.req = req;
    q.push_back(e);
  endtask

  task automatic monitor_pop();
    exp_t e;
    logic [7:0] v;
    e = q.pop_front();
    bus_read(2'd2, v);
    chk({e.req, " data"}, v, e.data);
    bus_read(2'd1, v);
    chk({e.req, " status"}, v, {5'b0, e.stat});
  endtask

  task automatic clear_flags();
    logic [7:0] v;
    bus_read(2'd1, v);
    bus_write(2'd1, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    bus_read(2'd0, v); chk("R12 ctrl", v, 8'h00);
    bus_read(2'd1, v); chk("R12 status", v, 8'h00);
    chk("R12 irqs", {6'b0, irq_full, irq_err}, 8'h00);

    // R3 R2 plain 8-bit character, full irq enabled
    bus_write(2'd0, 8'h21);
    send_frame(8'hA5, 0, 0, 0, 0, 0, 0, 0);
    expect_item(8'hA5, 3'b001, "R3");
    monitor_pop();
    @(negedge clk); chk("R11 irq_full", {7'b0, irq_full}, 8'h01);

    // R9 data read keeps full
    bus_read(2'd2, v);
    bus_read(2'd1, v); chk("R9 full kept", v, 8'h01);
    // R8 write 1 consumes arm; unarmed write 0 keeps flag
    bus_write(2'd1, 8'h01);
    bus_read(2'd0, v);
    bus_write(2'd1, 8'h00);
    bus_read(2'd2, v);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); chk("R8 write1 then unarmed write0", v, 8'h01);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); chk("R8 armed clear", v, 8'h00);
    @(negedge clk); chk("R11 irq_full low", {7'b0, irq_full}, 8'h00);

    // R2 R4 7-bit even parity, good
    bus_write(2'd0, 8'h0B);
    send_frame(8'h35, 1, 1, 0, 0, 0, 0, 0);
    expect_item(8'h35, 3'b001, "R2 7bit even");
    monitor_pop();
    clear_flags();

    // R2 7-bit mode with bit 7 set on the input
    send_frame(8'hC1, 1, 1, 0, 0, 0, 0, 0);
    expect_item(8'h41, 3'b001, "R2 7bit top zero");
    monitor_pop();
    clear_flags();

    // R4 R6 odd parity error
    bus_write(2'd0, 8'h47);
    send_frame(8'h3C, 0, 1, 1, 0, 1, 0, 0);
    expect_item(8'h3C, 3'b100, "R4 R6 parity error");
    monitor_pop();
    @(negedge clk); chk("R11 irq_err", {7'b0, irq_err}, 8'h01);

    // R7 frozen while error set
    send_frame(8'h55, 0, 1, 1, 0, 0, 0, 0);
    expect_item(8'h3C, 3'b100, "R7 frozen");
    monitor_pop();

    // R10 disable keeps flag
    bus_write(2'd0, 8'h46);
    bus_read(2'd1, v); chk("R10 flag kept", v, 8'h04);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); chk("R8 perr clear", v, 8'h00);
    send_frame(8'h55, 0, 1, 1, 0, 0, 0, 0);
    expect_item(8'h3C, 3'b000, "R10 disabled");
    monitor_pop();

    // R5 R6 framing error
    bus_write(2'd0, 8'h41);
    send_frame(8'h81, 0, 0, 0, 0, 0, 1, 0);
    expect_item(8'h81, 3'b010, "R5 R6 framing");
    monitor_pop();
    @(negedge clk); chk("R11 irq_err ferr", {7'b0, irq_err}, 8'h01);
    clear_flags();

    // R5 two stop bits: second unchecked, first checked
    bus_write(2'd0, 8'h51);
    send_frame(8'h7E, 0, 0, 0, 1, 0, 0, 1);
    expect_item(8'h7E, 3'b001, "R5 second stop ignored");
    monitor_pop();
    clear_flags();
    send_frame(8'h18, 0, 0, 0, 1, 0, 1, 0);
    expect_item(8'h18, 3'b010, "R5 first stop checked");
    monitor_pop();
    clear_flags();

    // R1 short low pulse dropped
    bus_write(2'd0, 8'h01);
    @(negedge clk); rxd = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    expect_item(8'h18, 3'b000, "R1 glitch");
    monitor_pop();

    // R3 recovery, R11 no irq without enables
    send_frame(8'hC3, 0, 0, 0, 0, 0, 0, 0);
    expect_item(8'hC3, 3'b001, "R3 recovery");
    monitor_pop();
    @(negedge clk); chk("R11 gated off", {6'b0, irq_full, irq_err}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule